// File: doc/BRIEF.md
# Software-Hinted Branch Prediction Unit

This unit predicts the direction of conditional branches from a hint word that the compiler places alongside each branch, not from observed history. A small table holds one entry per branch identifier. Installing a branch latches its hint word and a format selector into the entry. Each later lookup of that identifier returns a registered prediction one cycle later. The prediction says whether a direction is offered at all, and if so whether it is the first route (fall-through side) or the second route. Each execute strobe then moves the entry on to its next prediction.

Two hint formats exist. In countdown format, the two low bits choose between always-first, always-second, no prediction, and a counted mode. The counted mode predicts the first route for N executions and the second route after that, where N is the hint shifted right by two. In sequence format, the hint is a list of 2-bit fields, one per future execution, starting at the least significant field. Each field gives first route, second route, or no prediction. Once every field has been consumed, the entry gives no prediction until it is installed again.

Top module: `hint_branch_predictor`

## Requirements
- R1: While reset is high and on the cycle after it, pred_valid and pred_second are low. After reset every entry is invalid, so a lookup of any identifier returns pred_valid low until that identifier is installed.
- R2: A lookup strobe in cycle t sets pred_valid/pred_second in cycle t+1. A cycle without a lookup gives pred_valid low in the next cycle. pred_second is never high while pred_valid is low.
- R3: Countdown format (inst_mode = 0) with hint[1:0] = 0 predicts the first route (pred_valid 1, pred_second 0) on every lookup, however many executions occur.
- R4: Countdown format with hint[1:0] = 1 predicts the second route (pred_valid 1, pred_second 1) on every lookup.
- R5: Countdown format with hint[1:0] = 2 predicts the first route while fewer than N = hint[15:2] executions have occurred since install, and the second route from then on. N = 0 predicts the second route at once.
- R6: Countdown format with hint[1:0] = 3 gives pred_valid low on every lookup.
- R7: Sequence format (inst_mode = 1): the lookup after k executions since install uses field hint[2k+1:2k]. Value 0 means first route, 1 means second route, and 2 or 3 mean pred_valid low.
- R8: Sequence format: after 8 executions (all fields used) every lookup gives pred_valid low until the entry is installed again.
- R9: When install and execute target the same entry in one cycle, the install alone takes effect. An execute changes only the entry it names.
- R10: A lookup in the same cycle as an install or execute of the same entry reports the entry's state from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_en | input | 1 | Install strobe |
| inst_id | input | ID_W (2) | Entry to install |
| inst_mode | input | 1 | Hint format: 0 countdown, 1 sequence |
| inst_hint | input | HINT_W (16) | Hint word |
| look_en | input | 1 | Lookup strobe |
| look_id | input | ID_W (2) | Entry to look up |
| exec_en | input | 1 | Execute strobe, advances the entry |
| exec_id | input | ID_W (2) | Entry executed |
| pred_valid | output | 1 | A direction is predicted (registered) |
| pred_second | output | 1 | Predicted direction is the second route (registered) |

## Verification
The assertions assume that reset is held for at least one clock before any strobe, and that the identifier inputs are known whenever their strobe is high. They also assume that lookups of a not-yet-installed entry may coincide with an install of that same entry. The bench drives every identifier and mode as a defined value at all times. It applies reset before any traffic and keeps counted hints small in its random phase, so that the switch from first to second route happens within the run. It also deliberately pairs lookups, installs and executes on the same entry in one cycle.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_SEQ   = 1'b1
  } hint_mode_e;

  localparam logic [1:0] KIND_FIRST  = 2'd0;
  localparam logic [1:0] KIND_SECOND = 2'd1;
  localparam logic [1:0] KIND_COUNT  = 2'd2;
  localparam logic [1:0] KIND_NONE   = 2'd3;
endpackage

// File: rtl/hbp_decode.sv
module hbp_decode
  import hbp_pkg::*;
#(
  parameter int HINT_W = 16,
  parameter int LEFT_W = 4
) (
  input  logic              e_valid,
  input  hint_mode_e        e_mode,
  input  logic [1:0]        e_kind,
  input  logic [HINT_W-1:0] e_data,
  input  logic [LEFT_W-1:0] e_left,
  output logic              d_valid,
  output logic              d_second
);
  always_comb begin
    d_valid  = 1'b0;
    d_second = 1'b0;
    if (e_valid) begin
      if (e_mode == MODE_COUNT) begin
        case (e_kind)
          KIND_FIRST:  d_valid = 1'b1;
          KIND_SECOND: begin d_valid = 1'b1; d_second = 1'b1; end
          KIND_COUNT:  begin d_valid = 1'b1; d_second = (e_data == '0); end
          default:     d_valid = 1'b0;
        endcase
      end else if (e_left != '0) begin
        case (e_data[1:0])
          2'd0:    d_valid = 1'b1;
          2'd1:    begin d_valid = 1'b1; d_second = 1'b1; end
          default: d_valid = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/hbp_advance.sv
module hbp_advance
  import hbp_pkg::*;
#(
  parameter int HINT_W = 16,
  parameter int LEFT_W = 4
) (
  input  hint_mode_e        e_mode,
  input  logic [1:0]        e_kind,
  input  logic [HINT_W-1:0] e_data,
  input  logic [LEFT_W-1:0] e_left,
  output logic [HINT_W-1:0] n_data,
  output logic [LEFT_W-1:0] n_left
);
  always_comb begin
    n_data = e_data;
    n_left = e_left;
    if (e_mode == MODE_COUNT) begin
      if (e_kind == KIND_COUNT && e_data != '0)
        n_data = e_data - 1'b1;
    end else if (e_left != '0) begin
      n_data = e_data >> 2;
      n_left = e_left - 1'b1;
    end
  end
endmodule

// File: rtl/hint_branch_predictor.sv
module hint_branch_predictor
  import hbp_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int HINT_W  = 16,
  localparam int ID_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inst_en,
  input  logic [ID_W-1:0]   inst_id,
  input  logic              inst_mode,
  input  logic [HINT_W-1:0] inst_hint,
  input  logic              look_en,
  input  logic [ID_W-1:0]   look_id,
  input  logic              exec_en,
  input  logic [ID_W-1:0]   exec_id,
  output logic              pred_valid,
  output logic              pred_second
);
  localparam int FIELDS = HINT_W / 2;
  localparam int LEFT_W = $clog2(FIELDS + 1);

  logic              e_valid [ENTRIES];
  hint_mode_e        e_mode  [ENTRIES];
  logic [1:0]        e_kind  [ENTRIES];
  logic [HINT_W-1:0] e_data  [ENTRIES];
  logic [LEFT_W-1:0] e_left  [ENTRIES];
  logic [HINT_W-1:0] adv_data[ENTRIES];
  logic [LEFT_W-1:0] adv_left[ENTRIES];
  logic [ENTRIES-1:0] entry_valid;

  hint_mode_e        load_mode;
  logic [HINT_W-1:0] load_data;
  logic [LEFT_W-1:0] load_left;

  always_comb begin
    load_mode = hint_mode_e'(inst_mode);
    if (load_mode == MODE_COUNT) begin
      load_data = inst_hint >> 2;
      load_left = '0;
    end else begin
      load_data = inst_hint;
      load_left = LEFT_W'(FIELDS);
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    hbp_advance #(.HINT_W(HINT_W), .LEFT_W(LEFT_W)) u_adv (
      .e_mode (e_mode[i]),
      .e_kind (e_kind[i]),
      .e_data (e_data[i]),
      .e_left (e_left[i]),
      .n_data (adv_data[i]),
      .n_left (adv_left[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        e_valid[i] <= 1'b0;
        e_mode[i]  <= MODE_COUNT;
        e_kind[i]  <= '0;
        e_data[i]  <= '0;
        e_left[i]  <= '0;
      end else if (inst_en && inst_id == ID_W'(i)) begin
        e_valid[i] <= 1'b1;
        e_mode[i]  <= load_mode;
        e_kind[i]  <= inst_hint[1:0];
        e_data[i]  <= load_data;
        e_left[i]  <= load_left;
      end else if (exec_en && exec_id == ID_W'(i) && e_valid[i]) begin
        e_data[i]  <= adv_data[i];
        e_left[i]  <= adv_left[i];
      end
    end

    assign entry_valid[i] = e_valid[i];
  end

  logic dec_valid, dec_second;

  hbp_decode #(.HINT_W(HINT_W), .LEFT_W(LEFT_W)) u_dec (
    .e_valid  (e_valid[look_id]),
    .e_mode   (e_mode[look_id]),
    .e_kind   (e_kind[look_id]),
    .e_data   (e_data[look_id]),
    .e_left   (e_left[look_id]),
    .d_valid  (dec_valid),
    .d_second (dec_second)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_second <= 1'b0;
    end else begin
      pred_valid  <= look_en && dec_valid;
      pred_second <= look_en && dec_valid && dec_second;
    end
  end
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker #(
  parameter int ENTRIES = 4,
  parameter int ID_W    = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               inst_en,
  input logic [ID_W-1:0]    inst_id,
  input logic               look_en,
  input logic [ID_W-1:0]    look_id,
  input logic               pred_valid,
  input logic               pred_second,
  input logic [ENTRIES-1:0] entry_valid
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (entry_valid == '0 && !pred_valid && !pred_second));

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !look_en |=> !pred_valid);

  assert_second_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    pred_second |-> pred_valid);

  assert_install_wins_R9: assert property (@(posedge clk) disable iff (rst)
    inst_en |=> entry_valid[$past(inst_id)]);

  assert_preupdate_read_R10: assert property (@(posedge clk) disable iff (rst)
    (look_en && inst_en && look_id == inst_id && !entry_valid[look_id]) |=> !pred_valid);
endmodule

bind hint_branch_predictor hbp_checker #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .inst_en     (inst_en),
  .inst_id     (inst_id),
  .look_en     (look_en),
  .look_id     (look_id),
  .pred_valid  (pred_valid),
  .pred_second (pred_second),
  .entry_valid (entry_valid)
);

// File: tb/tb_hint_branch_predictor.sv
module tb_hint_branch_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inst_en = 1'b0, inst_mode = 1'b0, look_en = 1'b0, exec_en = 1'b0;
  logic [1:0]  inst_id = '0, look_id = '0, exec_id = '0;
  logic [15:0] inst_hint = '0;
  logic        pred_valid, pred_second;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit        mv[4];
  bit        mm[4];
  bit [1:0]  mk[4];
  int        mc[4];
  bit [15:0] ms[4];
  int        ml[4];

  always #10 clk = ~clk;

  hint_branch_predictor dut (
    .clk(clk), .rst(rst),
    .inst_en(inst_en), .inst_id(inst_id), .inst_mode(inst_mode), .inst_hint(inst_hint),
    .look_en(look_en), .look_id(look_id),
    .exec_en(exec_en), .exec_id(exec_id),
    .pred_valid(pred_valid), .pred_second(pred_second)
  );

  function automatic bit [1:0] exp_pred(int i);
    if (!mv[i]) return 2'b00;
    if (!mm[i]) begin
      case (mk[i])
        2'd0: return 2'b10;
        2'd1: return 2'b11;
        2'd2: return (mc[i] == 0) ? 2'b11 : 2'b10;
        default: return 2'b00;
      endcase
    end
    if (ml[i] == 0) return 2'b00;
    case (ms[i][1:0])
      2'd0: return 2'b10;
      2'd1: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(string tag, bit [1:0] exp);
    checks++;
    if ({pred_valid, pred_second} !== exp) begin
      errors++;
      $display("FAIL %s: actual valid=%b second=%b expected valid=%b second=%b",
               tag, pred_valid, pred_second, exp[1], exp[0]);
    end
  endtask

  task automatic op(bit ie, int iid, bit imode, bit [15:0] ih,
                    bit le, int lid, bit xe, int xid, string tag);
    bit [1:0] exp;
    inst_en = ie; inst_id = 2'(iid); inst_mode = imode; inst_hint = ih;
    look_en = le; look_id = 2'(lid); exec_en = xe; exec_id = 2'(xid);
    exp = le ? exp_pred(lid) : 2'b00;
    if (xe && mv[xid] && !(ie && iid == xid)) begin
      if (!mm[xid]) begin
        if (mk[xid] == 2'd2 && mc[xid] > 0) mc[xid]--;
      end else if (ml[xid] > 0) begin
        ms[xid] = ms[xid] >> 2;
        ml[xid]--;
      end
    end
    if (ie) begin
      mv[iid] = 1'b1; mm[iid] = imode; mk[iid] = ih[1:0];
      mc[iid] = int'(ih >> 2); ms[iid] = ih; ml[iid] = 8;
    end
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic install(int id, bit mode, bit [15:0] h, string tag);
    op(1, id, mode, h, 0, 0, 0, 0, tag);
  endtask

  task automatic look_exec(int id, string tag);
    op(0, 0, 0, 16'h0, 1, id, 1, id, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2016));
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mm[i] = 0; mk[i] = 0; mc[i] = 0; ms[i] = 0; ml[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 during reset", 2'b00);
    rst = 1'b0;
    // R1: all entries invalid after reset
    for (int i = 0; i < 4; i++) op(0, 0, 0, 16'h0, 1, i, 0, 0, "R1 lookup after reset");
    // execute of an invalid entry has no effect (R9)
    op(0, 0, 0, 16'h0, 0, 0, 1, 0, "R9 exec invalid");
    op(0, 0, 0, 16'h0, 1, 0, 0, 0, "R9 exec invalid then lookup");

    // R3, R4, R6 countdown fixed kinds
    install(0, 0, 16'hABC0, "R2 install");
    install(1, 0, 16'h0005, "R2 install");
    install(2, 0, 16'h0013, "R2 install");
    for (int k = 0; k < 4; k++) begin
      look_exec(0, "R3 always first");
      look_exec(1, "R4 always second");
      look_exec(2, "R6 no prediction");
    end
    op(0, 0, 0, 16'h0, 0, 0, 0, 0, "R2 no lookup");

    // R5 counted, N = 3 then N = 0
    install(3, 0, 16'h000E, "R2 install");
    for (int k = 0; k < 6; k++) look_exec(3, "R5 count N=3");
    install(3, 0, 16'h0002, "R2 install");
    look_exec(3, "R5 count N=0");

    // R7 sequence fields, R8 exhaustion
    install(0, 1, 16'h9C63, "R2 install");
    for (int k = 0; k < 8; k++) look_exec(0, "R7 sequence field");
    for (int k = 0; k < 3; k++) look_exec(0, "R8 fields used up");
    install(1, 1, 16'h0000, "R2 install");
    for (int k = 0; k < 10; k++) look_exec(1, "R8 all-first then none");

    // R9 install wins over execute on same entry; execute touches only its own entry
    install(2, 0, 16'h000A, "R2 install");
    look_exec(2, "R9 setup");
    op(1, 2, 0, 16'h000A, 0, 0, 1, 2, "R9 install with exec");
    op(0, 0, 0, 16'h0, 1, 3, 1, 2, "R9 other entry untouched");
    for (int k = 0; k < 3; k++) look_exec(2, "R9 count after reinstall");

    // R10 lookup sees pre-update state
    op(1, 1, 0, 16'h0003, 1, 1, 0, 0, "R10 lookup during install");
    op(0, 0, 0, 16'h0, 1, 1, 0, 0, "R10 after install");
    install(3, 0, 16'h0006, "R2 install");
    op(0, 0, 0, 16'h0, 1, 3, 1, 3, "R10 lookup during exec");
    op(0, 0, 0, 16'h0, 1, 3, 0, 0, "R10 after exec");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit ie, im, le, xe;
      bit [15:0] h;
      ie = ($urandom_range(0, 9) == 0);
      im = $urandom_range(0, 1);
      h  = 16'($urandom);
      if (!im) h[15:6] = '0;
      le = ($urandom_range(0, 3) != 0);
      xe = ($urandom_range(0, 1) == 1);
      op(ie, $urandom_range(0, 3), im, h, le, $urandom_range(0, 3),
         xe, $urandom_range(0, 3), "R2 random traffic");
    end
    op(0, 0, 0, 16'h0, 0, 0, 0, 0, "R2 idle end");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule